// File: doc/BRIEF.md
# Vector Unit-Stride Load Sequencer

This block carries out one contiguous vector load for 8-, 16- or 32-bit elements on a vector unit whose registers are 128 bits wide, so each register holds four 32-bit words. The caller starts it with four values: a byte base address, the active element count, the element-width field taken from the vector type CSR, and the first destination register with the encoded element width. The block then steps through memory. It reads whole 32-bit words while at least a full word of elements remains. Any elements left at the end are fetched as bytes or as one halfword. Each access becomes one write into the register file, with a byte-enable mask, and the block moves across register boundaries as each register fills.

Two faults are handled inside the block. The first is an element width wider than the configured one. In that case the block makes no access and reports an update of the vector type CSR (illegal bit only) and of the length CSR (zero). The second is a register group that would run past the last architectural register. In that case the block stops before the offending access and raises an illegal flag.

Memory is a synchronous read port: data returns one cycle after the request. The register file takes a word write with per-byte enables.

Top module: `vld_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `mem_req_o`, `vrf_we_o`, `csr_we_o` and `illegal_o` are all low.
- R2: The width code `eew_i` is 0 for 8 bits, 1 for 16 bits and 2 for 32 bits. When `eew_i` is greater than `vsew_i`, the block makes no memory read and no register write. One cycle after `start_i` is accepted it pulses `done_o` with `csr_we_o`=1, `csr_vtype_o`=32'h8000_0000 and `csr_vl_o`=0.
- R3: A full-word access reads with `mem_size_o`=2 (0 is byte, 1 is halfword). It writes the returned word with `vrf_be_o`=4'b1111. The byte at the lowest address lands in bits [7:0].
- R4: Full-word accesses start at the base address and advance by 4 each time. `vrf_word_o` counts 0 to 3 within a register. Full words are used while at least 4 (8-bit), 2 (16-bit) or 1 (32-bit) elements remain.
- R5: After the fourth word of a register, `vrf_word_o` returns to 0 and `vrf_idx_o` advances by one from the start register.
- R6: For 8-bit elements, the vl mod 4 leftover elements are read one byte at a time with `mem_size_o`=0, at consecutive addresses after the last full word. Leftover k is written into byte lane k of the next word, using a one-hot `vrf_be_o`. The other lanes are not enabled.
- R7: For 16-bit elements, an odd leftover element is read with `mem_size_o`=1 and written into the low half of the next word with `vrf_be_o`=4'b0011.
- R8: When the destination index (start register plus group offset) of the next access would exceed 31, that access and all later ones are not issued. `done_o` pulses with `illegal_o`=1.
- R9: A vector length of 0 completes one cycle after start with no memory read and no register write.
- R10: Each access takes a request cycle and then a write cycle. `done_o` is a one-cycle pulse in the cycle after the last write, and `busy_o` is high from acceptance through `done_o`. A `start_i` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted when idle |
| base_addr_i | input | 32 | Byte base address from the scalar register |
| vl_i | input | 8 | Element count |
| vsew_i | input | 3 | Element-width field of the vector type CSR (bits [5:3]) |
| eew_i | input | 2 | Encoded element width of the load |
| vd_i | input | 5 | First destination register |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Register-group overflow, valid with done_o |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Read byte address |
| mem_size_o | output | 2 | Access size: 0 byte, 1 halfword, 2 word |
| mem_rdata_i | input | 32 | Read data, low-aligned, one cycle after request |
| vrf_we_o | output | 1 | Register file write strobe |
| vrf_idx_o | output | 5 | Destination register index |
| vrf_word_o | output | 2 | Word index within the register |
| vrf_wdata_o | output | 32 | Write data placed in lanes |
| vrf_be_o | output | 4 | Byte enables |
| csr_we_o | output | 1 | CSR update strobe for the width fault |
| csr_vtype_o | output | 32 | New vector type value |
| csr_vl_o | output | 8 | New vector length value |

## Verification
Some properties are checked by assertions on every cycle:
- a write always follows a request, and a request is always followed by a write;
- `done_o` is a single pulse;
- the latched operation does not change while running;
- a width fault or an overflow stop issues no access in the cycle before completion;
- tail accesses come only after all full words.

The bench covers what only a comparison against a reference can show. Its reference compares every request and write in order, including addresses, lanes, enables and register walking, for each width. It also checks the byte and halfword tails, and the exact point at which overflow stops an operation in both the word loop and the tail. Finally, it checks the latency of each operation and confirms that a start arriving mid-run has no effect.

// File: rtl/vld_pkg.sv
package vld_pkg;
  typedef enum logic [1:0] {EW_8 = 2'd0, EW_16 = 2'd1, EW_32 = 2'd2, EW_RSV = 2'd3} ew_e;
  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2} sz_e;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP, ST_FIN} st_e;
  localparam logic [31:0] VTYPE_ILL = 32'h8000_0000;
endpackage

// File: rtl/vld_width_chk.sv
module vld_width_chk
  import vld_pkg::*;
(
  input  ew_e        eew_i,
  input  logic [2:0] vsew_i,
  output logic       ill_o
);
  assign ill_o = {1'b0, eew_i} > vsew_i;
endmodule

// File: rtl/vld_walker.sv
module vld_walker
  import vld_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int VL_W   = 8,
  parameter int WORDS  = 4,
  parameter int ROFF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic              step_i,
  input  ew_e               eew_i,
  input  logic [VL_W-1:0]   vl_i,
  output logic [XLEN-1:0]   acc_addr_o,
  output sz_e               acc_size_o,
  output logic [1:0]        acc_lane_o,
  output logic [$clog2(WORDS)-1:0] widx_o,
  output logic [ROFF_W-1:0] roff_o,
  output logic              last_o
);
  localparam int WIDX_W = $clog2(WORDS);
  localparam logic [WIDX_W-1:0] WLAST = WIDX_W'(WORDS - 1);

  logic [XLEN-1:0]   addr_q;
  logic [VL_W-1:0]   cnt_q;
  logic [WIDX_W-1:0] widx_q;
  logic [ROFF_W-1:0] roff_q;
  logic [1:0]        lane_q;
  logic [VL_W-1:0]   rem;
  logic [2:0]        elems;
  sz_e               size;

  always_comb begin
    rem = vl_i - cnt_q;
    unique case (eew_i)
      EW_32: begin size = SZ_W; elems = 3'd1; end
      EW_16: begin
        if (rem >= VL_W'(2)) begin size = SZ_W; elems = 3'd2; end
        else                 begin size = SZ_H; elems = 3'd1; end
      end
      default: begin
        if (rem >= VL_W'(4)) begin size = SZ_W; elems = 3'd4; end
        else                 begin size = SZ_B; elems = 3'd1; end
      end
    endcase
  end

  assign acc_size_o = size;
  assign acc_lane_o = lane_q;
  assign acc_addr_o = (size == SZ_W) ? addr_q : addr_q + XLEN'(lane_q);
  assign widx_o     = widx_q;
  assign roff_o     = roff_q;
  assign last_o     = ({1'b0, cnt_q} + (VL_W+1)'(elems)) == {1'b0, vl_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
      widx_q <= '0;
      roff_q <= '0;
      lane_q <= '0;
    end else if (load_i) begin
      addr_q <= base_i;
      cnt_q  <= '0;
      widx_q <= '0;
      roff_q <= '0;
      lane_q <= '0;
    end else if (step_i) begin
      cnt_q <= cnt_q + VL_W'(elems);
      if (size == SZ_W) begin
        addr_q <= addr_q + XLEN'(4);
        if (widx_q == WLAST) begin
          widx_q <= '0;
          roff_q <= roff_q + ROFF_W'(1);
        end else begin
          widx_q <= widx_q + WIDX_W'(1);
        end
      end else begin
        lane_q <= lane_q + 2'd1;
      end
    end
  end

  AST_TAIL_AFTER_WORDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && size == SZ_W) |-> lane_q == 2'd0);  // R6
  AST_CNT_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> cnt_q < vl_i);  // R4
endmodule

// File: rtl/vld_lane_pack.sv
module vld_lane_pack
  import vld_pkg::*;
#(
  parameter int NLANE = 4
) (
  input  sz_e                 size_i,
  input  logic [1:0]          lane_i,
  input  logic [8*NLANE-1:0]  rdata_i,
  output logic [8*NLANE-1:0]  wdata_o,
  output logic [NLANE-1:0]    be_o
);
  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic sel;
    always_comb begin
      unique case (size_i)
        SZ_W:    sel = 1'b1;
        SZ_H:    sel = (l < 2);
        default: sel = (lane_i == 2'(l));
      endcase
    end
    assign be_o[l] = sel;
    // byte tail takes rdata low byte; word and half keep lane position
    assign wdata_o[8*l +: 8] = !sel ? 8'h00 :
                               (size_i == SZ_B) ? rdata_i[7:0] : rdata_i[8*l +: 8];
  end
endmodule

// File: rtl/vld_seq.sv
module vld_seq
  import vld_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int XLEN = 32,
  parameter int VL_W = 8,
  parameter int NREG = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [XLEN-1:0]         base_addr_i,
  input  logic [VL_W-1:0]         vl_i,
  input  logic [2:0]              vsew_i,
  input  logic [1:0]              eew_i,
  input  logic [$clog2(NREG)-1:0] vd_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    illegal_o,
  output logic                    mem_req_o,
  output logic [XLEN-1:0]         mem_addr_o,
  output logic [1:0]              mem_size_o,
  input  logic [XLEN-1:0]         mem_rdata_i,
  output logic                    vrf_we_o,
  output logic [$clog2(NREG)-1:0] vrf_idx_o,
  output logic [$clog2(VLEN/XLEN)-1:0] vrf_word_o,
  output logic [XLEN-1:0]         vrf_wdata_o,
  output logic [XLEN/8-1:0]       vrf_be_o,
  output logic                    csr_we_o,
  output logic [XLEN-1:0]         csr_vtype_o,
  output logic [VL_W-1:0]         csr_vl_o
);
  localparam int WORDS  = VLEN / XLEN;
  localparam int WIDX_W = $clog2(WORDS);
  localparam int REG_W  = $clog2(NREG);
  localparam int ROFF_W = VL_W;
  localparam int DST_W  = ROFF_W + 1;

  st_e             state_q;
  logic [REG_W-1:0] vd_q;
  ew_e             eew_q;
  logic [VL_W-1:0] vl_q;
  logic            fin_csr_q, fin_ovf_q;

  logic              width_ill;
  logic [XLEN-1:0]   acc_addr;
  sz_e               acc_size;
  logic [1:0]        acc_lane;
  logic [WIDX_W-1:0] widx;
  logic [ROFF_W-1:0] roff;
  logic              last;
  logic [DST_W-1:0]  dest;
  logic              ovf, load, step;

  vld_width_chk u_chk (
    .eew_i (ew_e'(eew_i)),
    .vsew_i(vsew_i),
    .ill_o (width_ill)
  );

  assign load = (state_q == ST_IDLE) && start_i;
  assign step = (state_q == ST_RSP);

  vld_walker #(.XLEN(XLEN), .VL_W(VL_W), .WORDS(WORDS), .ROFF_W(ROFF_W)) u_walk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .base_i    (base_addr_i),
    .step_i    (step),
    .eew_i     (eew_q),
    .vl_i      (vl_q),
    .acc_addr_o(acc_addr),
    .acc_size_o(acc_size),
    .acc_lane_o(acc_lane),
    .widx_o    (widx),
    .roff_o    (roff),
    .last_o    (last)
  );

  vld_lane_pack #(.NLANE(XLEN/8)) u_pack (
    .size_i (acc_size),
    .lane_i (acc_lane),
    .rdata_i(mem_rdata_i),
    .wdata_o(vrf_wdata_o),
    .be_o   (vrf_be_o)
  );

  assign dest = DST_W'(vd_q) + DST_W'(roff);
  assign ovf  = dest > DST_W'(NREG - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      vd_q      <= '0;
      eew_q     <= EW_8;
      vl_q      <= '0;
      fin_csr_q <= 1'b0;
      fin_ovf_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          vd_q      <= vd_i;
          eew_q     <= ew_e'(eew_i);
          vl_q      <= vl_i;
          fin_csr_q <= width_ill;
          fin_ovf_q <= 1'b0;
          state_q   <= (width_ill || vl_i == '0) ? ST_FIN : ST_REQ;
        end
        ST_REQ: begin
          if (ovf) begin
            fin_ovf_q <= 1'b1;
            state_q   <= ST_FIN;
          end else begin
            state_q <= ST_RSP;
          end
        end
        ST_RSP:  state_q <= last ? ST_FIN : ST_REQ;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = state_q != ST_IDLE;
  assign done_o      = state_q == ST_FIN;
  assign illegal_o   = done_o && fin_ovf_q;
  assign csr_we_o    = done_o && fin_csr_q;
  assign csr_vtype_o = csr_we_o ? VTYPE_ILL : '0;
  assign csr_vl_o    = '0;
  assign mem_req_o   = (state_q == ST_REQ) && !ovf;
  assign mem_addr_o  = acc_addr;
  assign mem_size_o  = acc_size;
  assign vrf_we_o    = step;
  assign vrf_idx_o   = dest[REG_W-1:0];
  assign vrf_word_o  = widx;

  AST_REQ_THEN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> vrf_we_o);  // R10
  AST_WRITE_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vrf_we_o |-> $past(mem_req_o));  // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R10
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> ($stable(vd_q) && $stable(vl_q) && $stable(eew_q)));  // R10
  AST_CSR_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_o |-> (!$past(mem_req_o) && !$past(vrf_we_o)));  // R2
  AST_OVF_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!$past(mem_req_o) && !vrf_we_o));  // R8
endmodule

// File: tb/tb_vld_seq.sv
module tb_vld_seq;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_addr_i = '0;
  logic [7:0]  vl_i = '0;
  logic [2:0]  vsew_i = '0;
  logic [1:0]  eew_i = '0;
  logic [4:0]  vd_i = '0;
  logic        busy_o, done_o, illegal_o, mem_req_o, vrf_we_o, csr_we_o;
  logic [31:0] mem_addr_o, vrf_wdata_o, csr_vtype_o;
  logic [31:0] mem_rdata_i = '0;
  logic [1:0]  mem_size_o, vrf_word_o;
  logic [4:0]  vrf_idx_o;
  logic [3:0]  vrf_be_o;
  logic [7:0]  csr_vl_o;

  always #(CLK_P/2) clk = ~clk;

  vld_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .base_addr_i(base_addr_i),
    .vl_i(vl_i), .vsew_i(vsew_i), .eew_i(eew_i), .vd_i(vd_i),
    .busy_o(busy_o), .done_o(done_o), .illegal_o(illegal_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_size_o(mem_size_o),
    .mem_rdata_i(mem_rdata_i), .vrf_we_o(vrf_we_o), .vrf_idx_o(vrf_idx_o),
    .vrf_word_o(vrf_word_o), .vrf_wdata_o(vrf_wdata_o), .vrf_be_o(vrf_be_o),
    .csr_we_o(csr_we_o), .csr_vtype_o(csr_vtype_o), .csr_vl_o(csr_vl_o)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string cur_req = "R1";

  logic [33:0] rq[$];   // {size, addr}
  logic [42:0] wq[$];   // {idx, word, data, be}
  bit exp_csr, exp_ill;
  int exp_lat;

  function automatic logic [7:0] mb(input logic [31:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (mem_req_o) begin
      case (mem_size_o)
        2'd0:    mem_rdata_i <= {24'h0, mb(mem_addr_o)};
        2'd1:    mem_rdata_i <= {16'h0, mb(mem_addr_o + 1), mb(mem_addr_o)};
        default: mem_rdata_i <= {mb(mem_addr_o + 3), mb(mem_addr_o + 2),
                                 mb(mem_addr_o + 1), mb(mem_addr_o)};
      endcase
    end
  end

  // Reference comparison every clock
  always @(negedge clk) begin
    if (rst_ni) begin
      if (mem_req_o) begin
        if (rq.size() == 0) check(0, cur_req, "unexpected read", {30'h0, mem_size_o, mem_addr_o}, 0);
        else begin
          logic [33:0] e;
          e = rq.pop_front();
          check({mem_size_o, mem_addr_o} == e, cur_req, "read size/addr",
                {30'h0, mem_size_o, mem_addr_o}, {30'h0, e});
        end
      end
      if (vrf_we_o) begin
        logic [42:0] act;
        act = {vrf_idx_o, vrf_word_o, vrf_wdata_o, vrf_be_o};
        if (wq.size() == 0) check(0, cur_req, "unexpected write", {21'h0, act}, 0);
        else begin
          logic [42:0] e;
          e = wq.pop_front();
          check(act == e, cur_req, "write idx/word/data/be", {21'h0, act}, {21'h0, e});
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog R10 act=%0d exp=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic build(input logic [31:0] base, input int vl, input int vd,
                       input int ew, input int vsew);
    int per, cnt, w, r, n;
    logic [31:0] a;
    exp_csr = 0; exp_ill = 0;
    if (ew > vsew) begin exp_csr = 1; exp_lat = 1; return; end
    per = (ew == 2) ? 1 : (ew == 1) ? 2 : 4;
    cnt = 0; a = base; w = 0; r = 0; n = 0;
    while (vl - cnt >= per) begin
      if (vd + r > 31) begin exp_ill = 1; break; end
      rq.push_back({2'd2, a});
      wq.push_back({5'(vd + r), 2'(w), mb(a + 3), mb(a + 2), mb(a + 1), mb(a), 4'hF});
      cnt += per; a += 4; n++; w++;
      if (w == 4) begin w = 0; r++; end
    end
    if (!exp_ill) begin
      for (int k = 0; cnt < vl; k++) begin
        if (vd + r > 31) begin exp_ill = 1; break; end
        if (ew == 1) begin
          rq.push_back({2'd1, a});
          wq.push_back({5'(vd + r), 2'(w), 16'h0, mb(a + 1), mb(a), 4'b0011});
        end else begin
          rq.push_back({2'd0, a + 32'(k)});
          wq.push_back({5'(vd + r), 2'(w), 32'(mb(a + 32'(k))) << (8 * k), 4'(1 << k)});
        end
        cnt++; n++;
      end
    end
    exp_lat = exp_ill ? 2 + 2 * n : 1 + 2 * n;
  endtask

  task automatic run(input string req, input logic [31:0] base, input int vl,
                     input int vd, input int ew, input int vsew, input bit intrude);
    int lat;
    bit seen;
    cur_req = req;
    build(base, vl, vd, ew, vsew);
    @(negedge clk);
    base_addr_i = base; vl_i = 8'(vl); vd_i = 5'(vd); eew_i = 2'(ew); vsew_i = 3'(vsew);
    start_i = 1'b1;
    lat = 0; seen = 0;
    while (!seen && lat < 600) begin
      @(negedge clk);
      lat++;
      start_i = intrude && (lat == 3);
      if (intrude && lat == 3) begin
        base_addr_i = 32'hDEAD_0000; vl_i = 8'd1; vd_i = 5'd0; eew_i = 2'd2; vsew_i = 3'd2;
      end
      if (done_o) seen = 1;
    end
    check(seen && lat == exp_lat, "R10", "done latency", 64'(lat), 64'(exp_lat));
    check(illegal_o == exp_ill, (req == "R2") ? "R2" : "R8", "illegal flag", 64'(illegal_o), 64'(exp_ill));
    check(csr_we_o == exp_csr, "R2", "csr write", 64'(csr_we_o), 64'(exp_csr));
    if (exp_csr)
      check(csr_vtype_o == 32'h8000_0000 && csr_vl_o == 8'h0, "R2", "csr values",
            {csr_vtype_o, 24'h0, csr_vl_o}, 64'h8000_0000_0000_0000);
    check(rq.size() == 0 && wq.size() == 0, req, "pending events",
          64'(rq.size() + wq.size()), 0);
    rq.delete(); wq.delete();
    @(negedge clk);
    check(!busy_o && !done_o, "R10", "idle after done", {62'h0, busy_o, done_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !mem_req_o && !vrf_we_o && !csr_we_o && !illegal_o,
          "R1", "outputs in reset",
          {58'h0, busy_o, done_o, mem_req_o, vrf_we_o, csr_we_o, illegal_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o, "R1", "idle after reset", {62'h0, busy_o, done_o}, 0);

    run("R3", 32'h0000_0100, 3, 4, 2, 2, 0);
    run("R4", 32'h0000_0402, 4, 0, 2, 3, 0);
    run("R5", 32'h0000_1000, 9, 8, 2, 2, 0);
    run("R6", 32'h0000_0200, 23, 1, 0, 0, 0);
    run("R6", 32'h0000_0301, 2, 3, 0, 1, 0);
    run("R7", 32'h0000_0500, 11, 2, 1, 1, 0);
    run("R7", 32'h0000_0600, 4, 6, 1, 2, 0);
    run("R2", 32'h0000_0700, 5, 1, 1, 0, 0);
    run("R2", 32'h0000_0700, 5, 1, 2, 1, 0);
    run("R8", 32'h0000_0800, 12, 30, 2, 2, 0);
    run("R8", 32'h0000_0900, 18, 31, 0, 0, 0);
    run("R9", 32'h0000_0A00, 0, 5, 0, 0, 0);
    run("R10", 32'h0000_0B00, 8, 10, 0, 0, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule